// File: doc/BRIEF.md
# Chainable Content-Addressable Memory Slice

This block is one slice of a small content-addressable memory. It stores a set of entries, each with a valid bit. It compares every valid entry against a comparand register and finds both the lowest-indexed matching entry and the lowest-indexed empty entry. Identical slices are stacked in a vertical chain. Two ripple chains run through the stack. A full chain (`full_in` to `full_out`) picks the one slice that holds the first empty entry of the whole stack. A match chain (`match_in` to `match_out`) picks the one slice that holds the highest-priority match: the first slice in the chain that has any match.

Each bus cycle (`cyc` high for one clock) carries an operation code and a data word. The slice decides whether to accept the cycle from the cascade state as well as from the operation. A cycle with `casc_en` high locks the chain for the cycles that follow. While the chain is locked, only the highest-match slice accepts work, unless the slice is in enhanced mode. A cycle with `casc_en` low releases the lock. Each slice also holds a page number. It is loaded through the full chain, so slices receive unique pages one after another during start-up. The page forms the upper part of the reported hit address.

Top module: `cam_slice`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, the comparand and the page are zero, the mode is standard and the chain is unlocked.
- R2: `match_out` equals `match_in` OR (any valid entry equals the comparand). When there is a local match, `hit_addr` is {page, index of the lowest matching entry}.
- R3: `full_out` is high exactly when `full_in` is high and every entry is valid.
- R4: Operation code 2 (push) writes the comparand into the lowest invalid entry and sets that entry valid. Only a slice with `full_in` high and `full_out` low can accept it.
- R5: Operation code 5 (page load) copies `wr_data` bits [PAGE_W-1:0] into the page. Only a slice with `full_in` high and `full_out` low can accept it.
- R6: Every cycle (`cyc` high) sets the lock to the value of `casc_en`. A cycle that arrives while the chain is unlocked is not held back by the lock, even when `casc_en` is high.
- R7: In standard mode, while the chain is locked and `casc_en` is high, only the highest-match slice accepts a cycle. This is the slice with `match_in` low and a local match.
- R8: A cycle with `casc_en` low that arrives while the chain is locked is accepted only by the highest-match slice. In every other slice it only unlocks the chain.
- R9: Operation code 6 sets enhanced mode from `wr_data[0]`. In enhanced mode, while locked with `casc_en` high, comparand loads (code 1) and mode writes (code 6) reach every slice.
- R10: Operation codes 3 (write hit) and 4 (drop hit) act only in the highest-match slice. Code 3 writes `wr_data` into the lowest matching entry. Code 4 clears that entry's valid bit. Code 7 (read hit) is also accepted only by the highest-match slice.
- R11: `resp` is high exactly when the current cycle is accepted. Code 0 (idle) is never accepted. Code 1 loads `wr_data` into the comparand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc | input | 1 | Bus cycle strobe, one clock per cycle |
| op | input | 3 | Operation code |
| wr_data | input | WIDTH | Data word of the cycle |
| casc_en | input | 1 | Enable-cascade; high locks the chain for the next cycle |
| full_in | input | 1 | All earlier slices are full (tie high on the first slice) |
| match_in | input | 1 | Some earlier slice has a match (tie low on the first slice) |
| full_out | output | 1 | This slice and all earlier slices are full |
| match_out | output | 1 | This slice or an earlier one has a match |
| resp | output | 1 | This slice accepts the current cycle |
| hit_addr | output | PAGE_W+IDXW | Page and lowest matching index |

## Verification
The assertions assume that `op` holds a defined code whenever `cyc` is high, and that the chain inputs stay stable for the whole clock. They also assume that PAGE_W is no wider than WIDTH. The bench drives a single slice and plays both neighbours itself: it sets `full_in` and `match_in` to each legal combination. It changes inputs only on the falling clock edge and keeps `cyc` high on every driven cycle, so the lock always follows the `casc_en` of the previous cycle.

// File: rtl/cam_slice_pkg.sv
`timescale 1ns/1ps
// Shared operation codes for the chainable CAM slice.
// Assumes a three-bit operation field on the bus.
package cam_slice_pkg;
    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_LOAD_CMP  = 3'd1,
        OP_PUSH_FREE = 3'd2,
        OP_WRITE_HIT = 3'd3,
        OP_DROP_HIT  = 3'd4,
        OP_SET_PAGE  = 3'd5,
        OP_SET_MODE  = 3'd6,
        OP_READ_HIT  = 3'd7
    } cam_op_e;
endpackage

// File: rtl/cam_first_set.sv
`timescale 1ns/1ps
// Finds the lowest set bit of a vector and reports whether any bit is set.
// Purely combinational; assumes N >= 1.
module cam_first_set #(
    parameter int N    = 16,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    vec,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = i[IDXW-1:0];
            end
        end
    end
endmodule

// File: rtl/cam_entry_array.sv
`timescale 1ns/1ps
// Entry storage with valid bits and a parallel compare against the comparand.
// Assumes at most one of wr_en / clr_en is high in a clock.
module cam_entry_array #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 16,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   cmp_val,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [WIDTH-1:0]   wr_val,
    input  logic               clr_en,
    input  logic [IDXW-1:0]    clr_idx,
    output logic [ENTRIES-1:0] valid_q,
    output logic [ENTRIES-1:0] match
);
    logic [WIDTH-1:0] data_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Hold one entry and its valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                data_q[g]  <= '0;
            end else if (wr_en && wr_idx == g[IDXW-1:0]) begin
                valid_q[g] <= 1'b1;
                data_q[g]  <= wr_val;
            end else if (clr_en && clr_idx == g[IDXW-1:0]) begin
                valid_q[g] <= 1'b0;
            end
        end

        // Compare this entry against the comparand.
        assign match[g] = valid_q[g] && (data_q[g] == cmp_val);
    end

    // R4 / R10: a write leaves its target valid; a drop leaves it invalid.
    a_r4_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);
    a_r10_drop_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> !valid_q[$past(clr_idx)]);
endmodule

// File: rtl/cam_cascade_ctrl.sv
`timescale 1ns/1ps
// Chain lock state and the accept decision for each bus cycle.
// Assumes hm_here / nf_here come from settled chain inputs in the same clock.
module cam_cascade_ctrl
    import cam_slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc,
    input  logic [2:0] op,
    input  logic       casc_en,
    input  logic       enhanced,
    input  logic       hm_here,
    input  logic       nf_here,
    output logic       accept,
    output logic       locked_q
);
    logic target_ok;
    logic gate_ok;

    // Operation-specific target: highest match, first free, or any slice.
    always_comb begin
        unique case (cam_op_e'(op))
            OP_WRITE_HIT, OP_DROP_HIT, OP_READ_HIT: target_ok = hm_here;
            OP_PUSH_FREE, OP_SET_PAGE:              target_ok = nf_here;
            OP_LOAD_CMP, OP_SET_MODE:               target_ok = 1'b1;
            default:                                target_ok = 1'b0;
        endcase
    end

    // Lock gate: open when unlocked, highest match only when locked.
    always_comb begin
        if (!locked_q)     gate_ok = 1'b1;
        else if (casc_en)  gate_ok = enhanced ? 1'b1 : hm_here;
        else               gate_ok = hm_here;
    end

    assign accept = cyc && gate_ok && target_ok;

    // Track the lock: each cycle records its enable-cascade level.
    always_ff @(posedge clk) begin
        if (!rst_n)   locked_q <= 1'b0;
        else if (cyc) locked_q <= casc_en;
    end

    // R7: locked in standard mode, only the highest match accepts.
    a_r7_std_lock_hm_only: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && casc_en && !enhanced && accept) |-> hm_here);
    // R8: an unlocking cycle acts only in the highest match.
    a_r8_unlock_hm_only: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !casc_en && accept) |-> hm_here);
    // R6: a cycle with enable-cascade low leaves the chain unlocked.
    a_r6_unlock_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && !casc_en) |=> !locked_q);
endmodule

// File: rtl/cam_slice.sv
`timescale 1ns/1ps
// One chainable CAM slice: comparand, entries, match and free-entry chains,
// lock control and a page number loaded through the full chain.
// Assumes PAGE_W <= WIDTH and that the first slice ties full_in high, match_in low.
module cam_slice
    import cam_slice_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 16,
    parameter int PAGE_W  = 8,
    localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cyc,
    input  logic [2:0]             op,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic                   casc_en,
    input  logic                   full_in,
    input  logic                   match_in,
    output logic                   full_out,
    output logic                   match_out,
    output logic                   resp,
    output logic [PAGE_W+IDXW-1:0] hit_addr
);
    logic [WIDTH-1:0]   comparand_q;
    logic [PAGE_W-1:0]  page_q;
    logic               enhanced_q;
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] match;
    logic               hit_any;
    logic [IDXW-1:0]    hit_idx;
    logic               free_any;
    logic [IDXW-1:0]    free_idx;
    logic               hm_here;
    logic               nf_here;
    logic               accept;
    logic               locked;
    logic               wr_en;
    logic               clr_en;
    logic [IDXW-1:0]    wr_idx;
    logic [WIDTH-1:0]   wr_val;

    cam_entry_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
        .clk(clk), .rst_n(rst_n), .cmp_val(comparand_q),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .clr_en(clr_en), .clr_idx(hit_idx),
        .valid_q(valid), .match(match)
    );

    cam_first_set #(.N(ENTRIES), .IDXW(IDXW)) u_hit_enc (
        .vec(match), .any(hit_any), .idx(hit_idx)
    );

    cam_first_set #(.N(ENTRIES), .IDXW(IDXW)) u_free_enc (
        .vec(~valid), .any(free_any), .idx(free_idx)
    );

    // Chain roles of this slice.
    assign hm_here   = !match_in && hit_any;
    assign nf_here   = full_in && free_any;
    assign full_out  = full_in && !free_any;
    assign match_out = match_in || hit_any;
    assign hit_addr  = {page_q, hit_idx};

    cam_cascade_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .op(op), .casc_en(casc_en),
        .enhanced(enhanced_q), .hm_here(hm_here), .nf_here(nf_here),
        .accept(accept), .locked_q(locked)
    );

    assign resp = accept;

    // Steer entry writes: push takes the comparand, write-hit takes bus data.
    always_comb begin
        wr_en  = accept && (op == OP_PUSH_FREE || op == OP_WRITE_HIT);
        clr_en = accept && (op == OP_DROP_HIT);
        wr_idx = (op == OP_PUSH_FREE) ? free_idx : hit_idx;
        wr_val = (op == OP_PUSH_FREE) ? comparand_q : wr_data;
    end

    // Comparand, page and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comparand_q <= '0;
            page_q      <= '0;
            enhanced_q  <= 1'b0;
        end else if (accept) begin
            if (op == OP_LOAD_CMP) comparand_q <= wr_data;
            if (op == OP_SET_PAGE) page_q      <= wr_data[PAGE_W-1:0];
            if (op == OP_SET_MODE) enhanced_q  <= wr_data[0];
        end
    end

    // R1: the first clock out of reset sees a cleared slice.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid == '0 && page_q == '0 && !enhanced_q && !locked));
    // R4: an accepted push adds exactly one valid entry.
    a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (resp && op == OP_PUSH_FREE) |=> ($countones(valid) == $past($countones(valid)) + 1));
    // R5: the page changes only through an accepted page load.
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp && op == OP_SET_PAGE) |=> $stable(page_q));
    // R3: a push is never accepted when this slice reports full.
    a_r3_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
        (resp && op == OP_PUSH_FREE) |-> !full_out);
endmodule

// File: tb/test_cam_slice.sv
`timescale 1ns/1ps
module test_cam_slice;
    import cam_slice_pkg::*;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int P  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [W-1:0]  wr_data = '0;
    logic          casc_en = 1'b0;
    logic          full_in = 1'b1;
    logic          match_in = 1'b0;
    logic          full_out;
    logic          match_out;
    logic          resp;
    logic [P+IW-1:0] hit_addr;

    int checks = 0;
    int errors = 0;

    // Bench-side model state.
    logic [W-1:0] m_d [N];
    logic         m_v [N];
    logic [W-1:0] m_cmp;
    logic [P-1:0] m_page;
    logic         m_enh;
    logic         m_lock;

    cam_slice #(.ENTRIES(N), .WIDTH(W), .PAGE_W(P)) i_cam_slice (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .op(op), .wr_data(wr_data),
        .casc_en(casc_en), .full_in(full_in), .match_in(match_in),
        .full_out(full_out), .match_out(match_out), .resp(resp), .hit_addr(hit_addr)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, check outputs against the model, advance the model.
    task automatic step(input logic [2:0] o, input logic [W-1:0] d,
                        input logic ce, input logic fi, input logic mi, input string tag);
        logic any, allv, hm, nf, tgt, gate, act;
        int hidx, fidx;
        @(negedge clk);
        op = o; wr_data = d; casc_en = ce; full_in = fi; match_in = mi; cyc = 1'b1;
        #1;
        any = 1'b0; hidx = 0; allv = 1'b1; fidx = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_v[i] && m_d[i] == m_cmp) begin any = 1'b1; hidx = i; end
            if (!m_v[i]) begin allv = 1'b0; fidx = i; end
        end
        hm = !mi && any;
        nf = fi && !allv;
        case (o)
            3'd3, 3'd4, 3'd7: tgt = hm;
            3'd2, 3'd5:       tgt = nf;
            3'd1, 3'd6:       tgt = 1'b1;
            default:          tgt = 1'b0;
        endcase
        if (!m_lock)  gate = 1'b1;
        else if (ce)  gate = m_enh ? 1'b1 : hm;
        else          gate = hm;
        act = gate && tgt;
        check(resp == act, {tag, " resp"}, int'(resp), int'(act));
        check(full_out == (fi && allv), "R3 full_out", int'(full_out), int'(fi && allv));
        check(match_out == (mi || any), "R2 match_out", int'(match_out), int'(mi || any));
        if (any)
            check(hit_addr == {m_page, hidx[IW-1:0]}, "R2 hit_addr",
                  int'(hit_addr), int'({m_page, hidx[IW-1:0]}));
        @(posedge clk);
        if (act) begin
            case (o)
                3'd1: m_cmp = d;
                3'd2: begin m_d[fidx] = m_cmp; m_v[fidx] = 1'b1; end
                3'd3: begin m_d[hidx] = d; m_v[hidx] = 1'b1; end
                3'd4: m_v[hidx] = 1'b0;
                3'd5: m_page = d[P-1:0];
                3'd6: m_enh = d[0];
                default: ;
            endcase
        end
        m_lock = ce;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin m_d[i] = '0; m_v[i] = 1'b0; end
        m_cmp = '0; m_page = '0; m_enh = 1'b0; m_lock = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: cleared slice after reset.
        #1;
        check(full_out == 1'b0, "R1 full_out", int'(full_out), 0);
        check(match_out == 1'b0, "R1 match_out", int'(match_out), 0);
        step(3'(OP_IDLE), 8'h00, 1'b0, 1'b1, 1'b0, "R11 idle");
        step(3'(OP_READ_HIT), 8'h00, 1'b0, 1'b1, 1'b0, "R1 no hit");

        // R5: page load only in the first-free slice.
        step(3'(OP_SET_PAGE), 8'h09, 1'b0, 1'b1, 1'b0, "R5 load");
        step(3'(OP_SET_PAGE), 8'h03, 1'b0, 1'b0, 1'b0, "R5 not free");

        // R4: fill every entry through push.
        for (int k = 0; k < N; k++) begin
            step(3'(OP_LOAD_CMP), 8'(8'h10 + k), 1'b0, 1'b1, 1'b0, "R11 load");
            step(3'(OP_PUSH_FREE), 8'h00, 1'b0, 1'b1, 1'b0, "R4 push");
        end
        step(3'(OP_PUSH_FREE), 8'h00, 1'b0, 1'b1, 1'b0, "R4 push when full");
        step(3'(OP_SET_PAGE), 8'h05, 1'b0, 1'b1, 1'b0, "R5 page when full");
        step(3'(OP_LOAD_CMP), 8'h11, 1'b0, 1'b1, 1'b0, "R11 load");
        step(3'(OP_READ_HIT), 8'h00, 1'b0, 1'b1, 1'b1, "R10 deferred read");
        step(3'(OP_READ_HIT), 8'h00, 1'b0, 1'b1, 1'b0, "R10 read");

        // R2: exhaustive comparand sweep with varying chain inputs.
        for (int v = 0; v < 256; v++)
            step(3'(OP_LOAD_CMP), 8'(v), 1'b0, 1'(v >> 1), 1'(v >> 2), "R2 sweep");

        // R10: write and drop at the highest match.
        step(3'(OP_LOAD_CMP), 8'h12, 1'b0, 1'b1, 1'b0, "R11 load");
        step(3'(OP_WRITE_HIT), 8'h77, 1'b0, 1'b1, 1'b0, "R10 write hit");
        step(3'(OP_LOAD_CMP), 8'h77, 1'b0, 1'b1, 1'b0, "R11 load");
        step(3'(OP_DROP_HIT), 8'h00, 1'b0, 1'b1, 1'b1, "R10 drop deferred");
        step(3'(OP_DROP_HIT), 8'h00, 1'b0, 1'b1, 1'b0, "R10 drop");
        step(3'(OP_LOAD_CMP), 8'h12, 1'b0, 1'b1, 1'b0, "R11 load");
        step(3'(OP_PUSH_FREE), 8'h00, 1'b0, 1'b1, 1'b0, "R4 refill");

        // R6..R8: standard-mode lock behaviour.
        step(3'(OP_LOAD_CMP), 8'h13, 1'b1, 1'b1, 1'b1, "R6 first locked cycle");
        step(3'(OP_READ_HIT), 8'h00, 1'b1, 1'b1, 1'b0, "R7 hm read");
        step(3'(OP_READ_HIT), 8'h00, 1'b1, 1'b1, 1'b1, "R7 deferred read");
        step(3'(OP_LOAD_CMP), 8'h55, 1'b1, 1'b1, 1'b1, "R7 not hm");
        step(3'(OP_LOAD_CMP), 8'h55, 1'b1, 1'b1, 1'b0, "R7 hm load");
        step(3'(OP_LOAD_CMP), 8'h13, 1'b1, 1'b1, 0, "R7 stuck no match");
        step(3'(OP_LOAD_CMP), 8'h13, 1'b0, 1'b1, 1'b0, "R8 unlock only");
        step(3'(OP_LOAD_CMP), 8'h13, 1'b0, 1'b1, 1'b0, "R8 after unlock");
        step(3'(OP_IDLE), 8'h00, 1'b1, 1'b1, 1'b0, "R6 lock");
        step(3'(OP_DROP_HIT), 8'h00, 1'b0, 1'b1, 1'b0, "R8 unlock at hm");

        // R9: enhanced mode.
        step(3'(OP_SET_MODE), 8'h01, 1'b0, 1'b1, 1'b0, "R9 set mode");
        step(3'(OP_LOAD_CMP), 8'hEE, 1'b1, 1'b1, 1'b0, "R9 lock");
        step(3'(OP_LOAD_CMP), 8'h10, 1'b1, 1'b1, 1'b1, "R9 load all");
        step(3'(OP_READ_HIT), 8'h00, 1'b1, 1'b1, 1'b1, "R9 read deferred");
        step(3'(OP_PUSH_FREE), 8'h00, 1'b1, 1'b1, 1'b0, "R9 push free");
        step(3'(OP_PUSH_FREE), 8'h00, 1'b1, 1'b1, 1'b0, "R9 push full");
        step(3'(OP_SET_MODE), 8'h00, 1'b1, 1'b1, 1'b1, "R9 mode write");

        // R11: mixed sweep over ops, chain inputs and lock states.
        r = 32'h1ACE_B00C;
        for (int s = 0; s < 2000; s++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            step(r[2:0], {5'b00010, r[5:3]}, r[6], r[7] | r[8], r[9] & r[10], "R11 mixed");
        end

        @(negedge clk);
        cyc = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule